// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the word address stream for one DMA channel that walks a rectangular region of memory. A start strobe captures a start byte address, a line length in words, a line stride in words and a line count minus one. The generator then offers one 32-bit-word address per beat on a valid/ready handshake. The bus master that consumes the addresses moves the data. The next address to be issued is always visible as a byte address, so software can work out how much of a request is left.

A line length of zero selects ring mode for double-buffered streaming. The address runs linearly through an area of stride × (line count) words and then returns to the start. A pulse marks the end of the first half of the area and another marks the end of the whole area, so the consumer can refill one half while the other is in use. Ring mode runs until it is paused through the enable or restarted. Strided mode ends with a finish pulse and returns to idle.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `done`, `half_evt` and `end_evt` are low and `cur_byte_addr` is zero.
- R2: A cycle with `start` high captures all configuration inputs. The first word address is `cfg_byte_addr` shifted right by two, and it is offered from the next cycle whenever `enable` is high.
- R3: With `cfg_xlen` nonzero (strided mode), the block issues `cfg_ylen`+1 lines of `cfg_xlen` consecutive words each, and each line starts `cfg_width` words after the start of the line before it.
- R4: The address advances only on a cycle where `addr_valid` and `addr_ready` are both high. While `addr_valid` is high and `addr_ready` is low, `addr_word` holds.
- R5: In strided mode, `done` is high for exactly one cycle, the cycle after the handshake of the last word. From that cycle `addr_valid` stays low until the next start.
- R6: With `cfg_xlen` zero (ring mode, `cfg_width` at least 1), the address steps one word per handshake through an area of `cfg_width`×(`cfg_ylen`+1) words. After the last word of the area it returns to the start word, and the walk never finishes by itself.
- R7: In ring mode, `half_evt` is high for one cycle after the handshake of the word at offset H−1, where H = `cfg_width`×((`cfg_ylen`+1)>>1). It is never raised when H is zero.
- R8: In ring mode, `end_evt` is high for one cycle after the handshake of the last word of the area. In that same cycle the offered address is the start word again.
- R9: While `enable` is low, `addr_valid` is low and the address holds. Raising `enable` resumes the walk at the held address, in both modes.
- R10: `cur_byte_addr` always equals the address of the next word to be issued, shifted left by two. After a strided job finishes, it is one word past the last word issued.
- R11: A start while a job is running abandons that job. The new configuration takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture configuration and begin a job |
| enable | input | 1 | Run enable; low pauses the walk |
| cfg_byte_addr | input | AW | Start byte address (low two bits dropped) |
| cfg_xlen | input | LW | Words per line; zero selects ring mode |
| cfg_width | input | SW | Line stride in words |
| cfg_ylen | input | LW | Number of lines minus one |
| addr_valid | output | 1 | A word address is offered |
| addr_ready | input | 1 | The consumer accepts the offered address |
| addr_word | output | AW-2 | Offered word address |
| cur_byte_addr | output | AW | Next address as a byte address |
| done | output | 1 | Strided job finished (one cycle) |
| half_evt | output | 1 | Ring half point reached (one cycle) |
| end_evt | output | 1 | Ring end reached, wrapped (one cycle) |

## Verification
The bench drives random and directed jobs whose stride exceeds the line length, so a design that advances to the next line by line length instead of by stride issues addresses inside the gaps. Ring jobs cover both even and odd line counts, and a single-line ring whose half point is zero. A wrong half-point formula or a wrap that comes one word early or late moves `half_evt` or `end_evt` off the handshake where the model expects it. Random back-pressure and enable drops expose a design that advances without a handshake or loses its place during a pause. A restart in the middle of a job catches counters that are not reloaded.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {MODE_WALK = 1'b0, MODE_RING = 1'b1} dma2d_mode_e;
endpackage

// File: rtl/dma2d_cfg.sv
module dma2d_cfg
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int SW = 12,
  localparam int WAW = AW - 2,
  localparam int PW = SW + LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     byte_addr,
  input  logic [LW-1:0]     xlen,
  input  logic [SW-1:0]     width,
  input  logic [LW-1:0]     ylen,
  output logic [WAW-1:0]    base_q,
  output logic [LW-1:0]     xlen_q,
  output logic [SW-1:0]     width_q,
  output logic [LW-1:0]     ylen_q,
  output dma2d_mode_e       mode_q,
  output logic [PW-1:0]     area,
  output logic [PW-1:0]     half
);
  logic [LW:0] lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      xlen_q  <= '0;
      width_q <= '0;
      ylen_q  <= '0;
      mode_q  <= MODE_WALK;
    end else if (load) begin
      base_q  <= byte_addr[AW-1:2];
      xlen_q  <= xlen;
      width_q <= width;
      ylen_q  <= ylen;
      mode_q  <= (xlen == '0) ? MODE_RING : MODE_WALK;
    end
  end

  // Area and half point in words, derived from captured values.
  assign lines = {1'b0, ylen_q} + {{LW{1'b0}}, 1'b1};
  assign area  = PW'(width_q) * PW'(lines);
  assign half  = PW'(width_q) * PW'(lines >> 1);
endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk #(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int SW = 12,
  localparam int WAW = AW - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [WAW-1:0] load_base,
  input  logic           step,
  input  logic [LW-1:0]  xlen,
  input  logic [SW-1:0]  width,
  input  logic [LW-1:0]  ylen,
  output logic [WAW-1:0] ptr,
  output logic           last
);
  logic [WAW-1:0] line_q, line_d, ptr_d;
  logic [LW-1:0]  xcnt_q, xcnt_d, ycnt_q, ycnt_d;
  logic           line_end;

  assign line_end = (xcnt_q == xlen - LW'(1));
  assign last     = line_end && (ycnt_q == ylen);

  always_comb begin
    line_d = line_q;
    ptr_d  = ptr;
    xcnt_d = xcnt_q;
    ycnt_d = ycnt_q;
    if (load) begin
      line_d = load_base;
      ptr_d  = load_base;
      xcnt_d = '0;
      ycnt_d = '0;
    end else if (step) begin
      if (last) begin
        ptr_d = ptr + WAW'(1);
      end else if (line_end) begin
        line_d = line_q + WAW'(width);
        ptr_d  = line_q + WAW'(width);
        xcnt_d = '0;
        ycnt_d = ycnt_q + LW'(1);
      end else begin
        ptr_d  = ptr + WAW'(1);
        xcnt_d = xcnt_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      ptr    <= '0;
      xcnt_q <= '0;
      ycnt_q <= '0;
    end else if (load || step) begin
      line_q <= line_d;
      ptr    <= ptr_d;
      xcnt_q <= xcnt_d;
      ycnt_q <= ycnt_d;
    end
  end
endmodule

// File: rtl/dma2d_ring.sv
module dma2d_ring #(
  parameter int AW = 32,
  parameter int PW = 25,
  localparam int WAW = AW - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [WAW-1:0] load_base,
  input  logic [WAW-1:0] base,
  input  logic           step,
  input  logic [PW-1:0]  area,
  input  logic [PW-1:0]  half,
  output logic [WAW-1:0] ptr,
  output logic           half_hit,
  output logic           wrap_hit
);
  logic [PW-1:0]  off_q, off_d, off_inc;
  logic [WAW-1:0] ptr_d;

  assign off_inc  = off_q + PW'(1);
  assign half_hit = (off_inc == half) && (half != '0);
  assign wrap_hit = (off_inc == area);

  always_comb begin
    off_d = off_q;
    ptr_d = ptr;
    if (load) begin
      off_d = '0;
      ptr_d = load_base;
    end else if (step) begin
      if (wrap_hit) begin
        off_d = '0;
        ptr_d = base;
      end else begin
        off_d = off_inc;
        ptr_d = ptr + WAW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      ptr   <= '0;
    end else if (load || step) begin
      off_q <= off_d;
      ptr   <= ptr_d;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          enable,
  input  logic [AW-1:0] cfg_byte_addr,
  input  logic [LW-1:0] cfg_xlen,
  input  logic [SW-1:0] cfg_width,
  input  logic [LW-1:0] cfg_ylen,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-3:0] addr_word,
  output logic [AW-1:0] cur_byte_addr,
  output logic          done,
  output logic          half_evt,
  output logic          end_evt
);
  localparam int WAW = AW - 2;
  localparam int PW  = SW + LW + 1;

  dma2d_mode_e    mode_q;
  logic [WAW-1:0] base_q, walk_ptr, ring_ptr;
  logic [LW-1:0]  xlen_q, ylen_q;
  logic [SW-1:0]  width_q;
  logic [PW-1:0]  area, half;
  logic           walk_last, ring_half, ring_wrap;
  logic           run_q, run_d, fire, step_walk, step_ring;
  logic           done_d, half_d, end_d;

  dma2d_cfg #(.AW(AW), .LW(LW), .SW(SW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(start), .byte_addr(cfg_byte_addr),
    .xlen(cfg_xlen), .width(cfg_width), .ylen(cfg_ylen),
    .base_q(base_q), .xlen_q(xlen_q), .width_q(width_q), .ylen_q(ylen_q),
    .mode_q(mode_q), .area(area), .half(half)
  );

  dma2d_walk #(.AW(AW), .LW(LW), .SW(SW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(start), .load_base(cfg_byte_addr[AW-1:2]),
    .step(step_walk), .xlen(xlen_q), .width(width_q), .ylen(ylen_q),
    .ptr(walk_ptr), .last(walk_last)
  );

  dma2d_ring #(.AW(AW), .PW(PW)) u_ring (
    .clk(clk), .rst_n(rst_n), .load(start), .load_base(cfg_byte_addr[AW-1:2]),
    .base(base_q), .step(step_ring), .area(area), .half(half),
    .ptr(ring_ptr), .half_hit(ring_half), .wrap_hit(ring_wrap)
  );

  assign addr_valid    = run_q && enable;
  assign fire          = addr_valid && addr_ready && !start;
  assign step_walk     = fire && (mode_q == MODE_WALK);
  assign step_ring     = fire && (mode_q == MODE_RING);
  assign addr_word     = (mode_q == MODE_RING) ? ring_ptr : walk_ptr;
  assign cur_byte_addr = {addr_word, 2'b00};

  always_comb begin
    run_d  = run_q;
    done_d = step_walk && walk_last;
    half_d = step_ring && ring_half;
    end_d  = step_ring && ring_wrap;
    if (start)       run_d = 1'b1;
    else if (done_d) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      done     <= 1'b0;
      half_evt <= 1'b0;
      end_evt  <= 1'b0;
    end else begin
      run_q    <= run_d;
      done     <= done_d;
      half_evt <= half_d;
      end_evt  <= end_d;
    end
  end
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          enable,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-3:0] addr_word,
  input logic [AW-1:0] cur_byte_addr,
  input logic          done,
  input logic          half_evt,
  input logic          end_evt
);
  // R9: no offer while paused
  a_r9_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> enable);

  // R4: stalled offer holds its address
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !start) |=> $stable(addr_word));

  // R9: pause holds the current address
  a_r9_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !start) |=> $stable(cur_byte_addr));

  // R5: after finishing no address is offered
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_valid);

  // R7: half event follows a handshake
  a_r7_half_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt |-> $past(addr_valid && addr_ready));

  // R8: end event follows a handshake
  a_r8_end_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> $past(addr_valid && addr_ready));

  // R5, R7, R8: events never coincide
  a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, half_evt, end_evt}));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_word(addr_word),
  .cur_byte_addr(cur_byte_addr), .done(done), .half_evt(half_evt),
  .end_evt(end_evt)
);

// File: tb/dma2d_addr_gen_test.sv
module dma2d_addr_gen_test;
  localparam int AW = 32;
  localparam int LW = 12;
  localparam int SW = 12;

  logic          clk, rst_n, start, enable, addr_ready;
  logic [AW-1:0] cfg_byte_addr;
  logic [LW-1:0] cfg_xlen, cfg_ylen;
  logic [SW-1:0] cfg_width;
  logic          addr_valid, done, half_evt, end_evt;
  logic [AW-3:0] addr_word;
  logic [AW-1:0] cur_byte_addr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int seed_dummy;

  // reference model state
  bit          m_run, m_loop, m_first, m_restart;
  bit          e_done, e_half, e_end;
  logic [29:0] m_ptr, m_line, m_base;
  int          m_x, m_y, m_off, m_xlen, m_ylen, m_width, m_area, m_half;

  dma2d_addr_gen #(.AW(AW), .LW(LW), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
    .cfg_byte_addr(cfg_byte_addr), .cfg_xlen(cfg_xlen), .cfg_width(cfg_width),
    .cfg_ylen(cfg_ylen), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_word(addr_word), .cur_byte_addr(cur_byte_addr), .done(done),
    .half_evt(half_evt), .end_evt(end_evt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ring_area(int w, int y);
    return w * (y + 1);
  endfunction

  function automatic int ring_half(int w, int y);
    return w * ((y + 1) >> 1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check, update model, advance to next negedge
  task automatic cyc(input bit rdy, input bit en);
    bit fire;
    addr_ready = rdy;
    enable     = en;
    #1;
    chk(en ? "R4 valid" : "R9 valid", addr_valid, m_run && en);
    if (m_run && en)
      chk(m_restart ? "R11 addr" : (m_first ? "R2 addr" : (m_loop ? "R6 addr" : "R3 addr")),
          addr_word, m_ptr);
    chk("R10 cur_byte_addr", cur_byte_addr, {m_ptr, 2'b00});
    chk("R5 done", done, e_done);
    chk("R7 half_evt", half_evt, e_half);
    chk("R8 end_evt", end_evt, e_end);
    fire = m_run && en && rdy;
    e_done = 0; e_half = 0; e_end = 0;
    if (fire) begin
      m_first = 0; m_restart = 0;
      if (!m_loop) begin
        if (m_x == m_xlen - 1) begin
          if (m_y == m_ylen) begin
            e_done = 1; m_run = 0; m_ptr = m_ptr + 30'd1;
          end else begin
            m_line = m_line + 30'(m_width); m_ptr = m_line; m_x = 0; m_y++;
          end
        end else begin
          m_x++; m_ptr = m_ptr + 30'd1;
        end
      end else begin
        if (m_off + 1 == m_half && m_half != 0) e_half = 1;
        if (m_off + 1 == m_area) begin
          e_end = 1; m_off = 0; m_ptr = m_base;
        end else begin
          m_off++; m_ptr = m_ptr + 30'd1;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic launch(input logic [31:0] ba, input int x, input int w, input int y,
                        input bit restart);
    start = 1; addr_ready = 0;
    cfg_byte_addr = ba; cfg_xlen = LW'(x); cfg_width = SW'(w); cfg_ylen = LW'(y);
    @(posedge clk);
    @(negedge clk);
    start = 0;
    m_run = 1; m_loop = (x == 0); m_first = 1; m_restart = restart;
    m_base = ba[31:2]; m_ptr = ba[31:2]; m_line = ba[31:2];
    m_x = 0; m_y = 0; m_off = 0; m_xlen = x; m_ylen = y; m_width = w;
    m_area = ring_area(w, y); m_half = ring_half(w, y);
    e_done = 0; e_half = 0; e_end = 0;
  endtask

  task automatic run_walk(input int lim);
    for (int i = 0; i < lim && m_run; i++)
      cyc(($urandom % 4) != 0, ($urandom % 10) != 0);
    cyc(1, 1);
    cyc(1, 1);
  endtask

  task automatic run_ring(input int n);
    for (int i = 0; i < n; i++)
      cyc(($urandom % 4) != 0, ($urandom % 10) != 0);
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_2d01);
    rst_n = 0; start = 0; enable = 0; addr_ready = 0;
    cfg_byte_addr = '0; cfg_xlen = '0; cfg_width = '0; cfg_ylen = '0;
    m_run = 0; m_loop = 0; m_first = 0; m_restart = 0;
    e_done = 0; e_half = 0; e_end = 0; m_ptr = '0; m_base = '0; m_line = '0;
    m_x = 0; m_y = 0; m_off = 0; m_xlen = 1; m_ylen = 0; m_width = 1;
    m_area = 1; m_half = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", addr_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 half_evt", half_evt, 0);
    chk("R1 end_evt", end_evt, 0);
    chk("R1 cur_byte_addr", cur_byte_addr, 0);
    rst_n = 1;
    @(negedge clk);
    cyc(1, 1);

    // directed strided: gaps between lines (R3), full speed
    launch(32'h0000_1003, 3, 5, 2, 0);
    for (int i = 0; i < 12; i++) cyc(1, 1);
    // single-word job (R5)
    launch(32'h0000_2000, 1, 1, 0, 0);
    for (int i = 0; i < 4; i++) cyc(1, 1);
    // contiguous, stall heavy (R4)
    launch(32'h0000_3010, 4, 4, 1, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1);
    run_walk(100);
    // ring, even line count (R6 R7 R8)
    launch(32'h0000_4000, 0, 2, 3, 0);
    for (int i = 0; i < 20; i++) cyc(1, 1);
    // ring, odd line count with pauses (R9)
    launch(32'h0000_5004, 0, 3, 2, 0);
    for (int i = 0; i < 5; i++) cyc(1, 1);
    for (int i = 0; i < 4; i++) cyc(1, 0);
    for (int i = 0; i < 20; i++) cyc(1, 1);
    // ring, single line: no half event (R7)
    launch(32'h0000_6000, 0, 4, 0, 0);
    for (int i = 0; i < 12; i++) cyc(1, 1);
    // restart mid job (R11)
    launch(32'h0000_7000, 2, 6, 5, 0);
    for (int i = 0; i < 5; i++) cyc(1, 1);
    launch(32'h0000_8008, 3, 3, 1, 1);
    run_walk(100);

    // random jobs
    for (int j = 0; j < 120; j++) begin
      int x, w, y;
      x = $urandom % 6;
      w = (x == 0) ? 1 + ($urandom % 4) : x + ($urandom % 4);
      y = $urandom % 5;
      launch($urandom, x, w, y, 0);
      if (x == 0) begin
        run_ring(3 * ring_area(w, y) + 8);
        for (int i = 0; i < 2; i++) cyc(1, 0);
      end else begin
        run_walk(400);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule